// File: doc/BRIEF.md
# Integer Decode-Execute Unit

This unit takes one 32-bit instruction word per clock when the valid strobe is high. It decodes the word as either a register-format or an immediate-format instruction and reads up to two operands from an internal register file of 32 words. It computes an integer result and writes that result to the destination register on the next rising clock edge. It supports four register-format operations: add, subtract, signed set-less-than and unsigned set-less-than. It supports five immediate-format operations: add-immediate, signed and unsigned set-less-than-immediate, or-immediate and load-upper-immediate.

The result, its destination register number and a write strobe are shown combinationally on the ports during the cycle the instruction is presented. A surrounding pipeline can observe them there. Encodings outside the supported set raise an illegal-instruction flag, and nothing is written back. Memory access, control transfer, shifts, multiply and divide are handled elsewhere.

Top module: `intDxUnit`

## Requirements
- R1: The word is split as opcode = bits 31:26, rs = bits 25:21, rt = bits 20:16, rd = bits 15:11, shift amount = bits 10:6, function code = bits 5:0, and immediate = bits 15:0.
- R2: Opcode 0 selects the register format. The function code then selects the operation: 32 is add, 34 is sub (rs minus rt), 42 is slt and 43 is sltu. The operands are registers rs and rt, and the destination is rd.
- R3: In immediate format, the source is rs and the destination is rt. Opcode 8 (addi), opcode 10 (slti) and opcode 11 (sltiu) sign-extend the immediate to 32 bits. Opcode 13 (ori) zero-extends it.
- R4: Opcode 15 (lui) writes the immediate into bits 31:16 of the result and zeros into bits 15:0.
- R5: slt and slti compare as signed numbers. sltu and sltiu compare as unsigned numbers, using the sign-extended immediate for sltiu. Each writes 1 when the first operand is smaller and 0 otherwise.
- R6: Register 0 always reads as zero. An instruction whose destination is register 0 gives wbEn low and changes no register.
- R7: wbEn, wbAddr and wbData are valid in the same cycle as instrValid. The write takes effect at the next rising edge, and the following instruction reads the new value.
- R8: illegalInstr goes high and wbEn stays low in three cases: any opcode other than 0, 8, 10, 11, 13 or 15; opcode 0 with any other function code; or opcode 0 with a nonzero shift amount.
- R9: While instrValid is low, illegalInstr and wbEn are low.
- R10: An active-low asynchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | instrWord holds an instruction this cycle |
| instrWord | input | 32 | Instruction word |
| illegalInstr | output | 1 | Valid word is not a supported encoding |
| wbEn | output | 1 | A register write happens at the next edge |
| wbAddr | output | 5 | Destination register number |
| wbData | output | 32 | Result value to be written |

## Verification
Directed words test the boundaries. They check lui followed by ori to build a full 32-bit constant, and addi with a negative immediate. They check slt against sltu on operands whose sign bits differ, which separates the signed compare from the unsigned one. They check sltiu with an all-ones immediate, which separates sign extension from zero extension. They also cover writes aimed at register 0, back-to-back read-after-write, and words with a nonzero shift amount or an unknown opcode or function code. Seeded random words with random register numbers and immediates then mix all nine operations with illegal encodings and idle cycles. A bench model tracks the register file, so a wrong destination field or an extension rule applied to the wrong opcode shows up in later results.

// File: rtl/intDxPkg.sv
package intDxPkg;
  localparam int INSTR_W  = 32;
  localparam int OPC_W    = 6;
  localparam int REGSEL_W = 5;
  localparam int FN_W     = 6;
  localparam int IMM_W    = 16;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

  localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FN_W-1:0] FN_SLT  = 6'd42;
  localparam logic [FN_W-1:0] FN_SLTU = 6'd43;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU, ALU_OR, ALU_PASSB
  } aluOpT;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_UPPER
  } immKindT;

  typedef struct packed {
    logic    writeReq;
    logic    illegal;
    logic    useImm;
    logic    destIsRt;
    immKindT immKind;
    aluOpT   aluOp;
  } ctrlT;
endpackage

// File: rtl/intDxControl.sv
module intDxControl
  import intDxPkg::*;
(
  input  logic                instrValid,
  input  logic [OPC_W-1:0]    opcode,
  input  logic [FN_W-1:0]     funct,
  input  logic [REGSEL_W-1:0] shamt,
  output ctrlT                ctrl
);
  logic  known;
  ctrlT  dec;

  always_comb begin
    dec       = '0;
    dec.aluOp = ALU_ADD;
    dec.immKind = IMM_SIGN;
    known     = 1'b1;
    unique case (opcode)
      OPC_REG: begin
        case (funct)
          FN_ADD:  dec.aluOp = ALU_ADD;
          FN_SUB:  dec.aluOp = ALU_SUB;
          FN_SLT:  dec.aluOp = ALU_SLT;
          FN_SLTU: dec.aluOp = ALU_SLTU;
          default: known = 1'b0;
        endcase
        if (shamt != '0) known = 1'b0;
      end
      OPC_ADDI:  begin dec.useImm = 1'b1; dec.destIsRt = 1'b1; dec.aluOp = ALU_ADD;  end
      OPC_SLTI:  begin dec.useImm = 1'b1; dec.destIsRt = 1'b1; dec.aluOp = ALU_SLT;  end
      OPC_SLTIU: begin dec.useImm = 1'b1; dec.destIsRt = 1'b1; dec.aluOp = ALU_SLTU; end
      OPC_ORI: begin
        dec.useImm = 1'b1; dec.destIsRt = 1'b1;
        dec.immKind = IMM_ZERO; dec.aluOp = ALU_OR;
      end
      OPC_LUI: begin
        dec.useImm = 1'b1; dec.destIsRt = 1'b1;
        dec.immKind = IMM_UPPER; dec.aluOp = ALU_PASSB;
      end
      default: known = 1'b0;
    endcase
    dec.illegal  = instrValid & ~known;
    dec.writeReq = instrValid & known;
  end

  assign ctrl = dec;
endmodule

// File: rtl/intDxRegFile.sv
module intDxRegFile #(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  logic [DATA_W-1:0] regs [REG_COUNT];

  assign regs[0] = '0;

  for (genvar g = 1; g < REG_COUNT; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[g] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(g))
        regs[g] <= wrData;
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];
endmodule

// File: rtl/intDxDatapath.sv
module intDxDatapath
  import intDxPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  ctrlT               ctrl,
  output logic               wbEn,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [DATA_W-1:0]  wbData,
  output logic [DATA_W-1:0]  rsVal
);
  logic [ADDR_W-1:0] rsSel, rtSel, rdSel;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] rtVal, immExt, opB, aluOut;

  assign rsSel = instrWord[25:21];
  assign rtSel = instrWord[20:16];
  assign rdSel = instrWord[15:11];
  assign imm   = instrWord[IMM_W-1:0];

  intDxRegFile #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) i_rf (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (rsSel),
    .rdAddrB (rtSel),
    .rdDataA (rsVal),
    .rdDataB (rtVal),
    .wrEn    (wbEn),
    .wrAddr  (wbAddr),
    .wrData  (wbData)
  );

  always_comb begin
    unique case (ctrl.immKind)
      IMM_ZERO:  immExt = DATA_W'(imm);
      IMM_UPPER: immExt = {imm, {(DATA_W-IMM_W){1'b0}}};
      default:   immExt = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    endcase
  end

  assign opB = ctrl.useImm ? immExt : rtVal;

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_SUB:   aluOut = rsVal - opB;
      ALU_SLT:   aluOut = DATA_W'($signed(rsVal) < $signed(opB));
      ALU_SLTU:  aluOut = DATA_W'(rsVal < opB);
      ALU_OR:    aluOut = rsVal | opB;
      ALU_PASSB: aluOut = opB;
      default:   aluOut = rsVal + opB;
    endcase
  end

  assign wbAddr = ctrl.destIsRt ? rtSel : rdSel;
  assign wbData = aluOut;
  assign wbEn   = ctrl.writeReq && (wbAddr != '0);
endmodule

// File: rtl/intDxUnit.sv
module intDxUnit
  import intDxPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               illegalInstr,
  output logic               wbEn,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [DATA_W-1:0]  wbData
);
  ctrlT              ctrl;
  logic [DATA_W-1:0] rsVal;

  intDxControl i_ctrl (
    .instrValid (instrValid),
    .opcode     (instrWord[31:26]),
    .funct      (instrWord[5:0]),
    .shamt      (instrWord[10:6]),
    .ctrl       (ctrl)
  );

  intDxDatapath #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .ctrl      (ctrl),
    .wbEn      (wbEn),
    .wbAddr    (wbAddr),
    .wbData    (wbData),
    .rsVal     (rsVal)
  );

  assign illegalInstr = ctrl.illegal;
endmodule

// File: rtl/intDxChecker.sv
module intDxChecker (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [31:0] instrWord,
  input logic        illegalInstr,
  input logic        wbEn,
  input logic [4:0]  wbAddr,
  input logic [31:0] wbData,
  input logic [31:0] rsVal
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic       isCmp;
  assign opc   = instrWord[31:26];
  assign fn    = instrWord[5:0];
  assign isCmp = (opc == 6'd10) || (opc == 6'd11) ||
                 (opc == 6'd0 && (fn == 6'd42 || fn == 6'd43));

  AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && opc == 6'd15) |-> (wbData[15:0] == 16'd0)); // R4

  AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && isCmp) |-> (wbData[31:1] == 31'd0)); // R5

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord[25:21] == 5'd0) |-> (rsVal == 32'd0)); // R6

  AST_NO_WRITE_R0: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbAddr != 5'd0)); // R6

  AST_RAW_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |=> (!(instrValid && instrWord[25:21] == $past(wbAddr)) || rsVal == $past(wbData))); // R7

  AST_SHAMT_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opc == 6'd0 && instrWord[10:6] != 5'd0) |-> illegalInstr); // R8

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |-> !wbEn); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> (!wbEn && !illegalInstr)); // R9
endmodule

bind intDxUnit intDxChecker u_intDxChecker (
  .clk          (clk),
  .rstN         (rstN),
  .instrValid   (instrValid),
  .instrWord    (instrWord),
  .illegalInstr (illegalInstr),
  .wbEn         (wbEn),
  .wbAddr       (wbAddr),
  .wbData       (wbData),
  .rsVal        (rsVal)
);

// File: tb/test_intDxUnit.sv
`timescale 1ns/1ps
module test_intDxUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        illegalInstr, wbEn;
  logic [4:0]  wbAddr;
  logic [31:0] wbData;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] mdl [32];

  always #2 clk = ~clk;

  intDxUnit i_intDxUnit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .illegalInstr(illegalInstr), .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData)
  );

  function automatic logic [31:0] rEnc(input int rs, input int rt, input int rd,
                                       input int sh, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] iEnc(input int op, input int rs, input int rt,
                                       input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Independent model of the requirements R1..R8
  task automatic predict(input logic [31:0] w, output logic ill, output logic [4:0] dst,
                         output logic [31:0] val, output string tag);
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd, sh;
    logic [5:0]  fn;
    logic [31:0] a, b, sx, zx;
    op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; sh = w[10:6]; fn = w[5:0];
    a = mdl[rs]; b = mdl[rt];
    sx = {{16{w[15]}}, w[15:0]};
    zx = {16'd0, w[15:0]};
    ill = 1'b0; dst = rt; val = '0; tag = "R3";
    case (op)
      6'd0: begin
        dst = rd; tag = "R2";
        if (sh != 0) begin ill = 1'b1; tag = "R8"; end
        else case (fn)
          6'd32: val = a + b;
          6'd34: val = a - b;
          6'd42: begin val = {31'd0, $signed(a) < $signed(b)}; tag = "R5"; end
          6'd43: begin val = {31'd0, a < b}; tag = "R5"; end
          default: begin ill = 1'b1; tag = "R8"; end
        endcase
      end
      6'd8:  val = a + sx;
      6'd10: begin val = {31'd0, $signed(a) < $signed(sx)}; tag = "R5"; end
      6'd11: begin val = {31'd0, a < sx}; tag = "R5"; end
      6'd13: val = a | zx;
      6'd15: begin val = {w[15:0], 16'd0}; tag = "R4"; end
      default: begin ill = 1'b1; tag = "R8"; end
    endcase
  endtask

  task automatic issue(input logic [31:0] w);
    logic ill; logic [4:0] dst; logic [31:0] val; string tag;
    @(negedge clk);
    instrValid = 1'b1; instrWord = w;
    predict(w, ill, dst, val, tag);
    #1;
    check({tag, " illegal"}, {31'd0, illegalInstr}, {31'd0, ill});
    check({tag, " wbEn R6"}, {31'd0, wbEn}, {31'd0, !ill && dst != 0});
    if (!ill && dst != 0) begin
      check({tag, " wbAddr R1"}, {27'd0, wbAddr}, {27'd0, dst});
      check({tag, " wbData R7"}, wbData, val);
      mdl[dst] = val;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    instrValid = 1'b0; instrWord = $urandom;
    #1;
    check("R9 idle wbEn", {31'd0, wbEn}, 32'd0);
    check("R9 idle illegal", {31'd0, illegalInstr}, 32'd0);
  endtask

  initial begin : watchdog
    #400000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset wbEn", {31'd0, wbEn}, 32'd0);
    rstN = 1'b1;

    // R10: every register reads zero after reset (add rK, rK, r0)
    for (int k = 0; k < 32; k++) begin
      issue(rEnc(k, 0, k, 0, 32));
      if (k != 0) check("R10 reset value", wbData, 32'd0);
    end

    // R4 then R3: build a full constant with lui + ori
    issue(iEnc(15, 0, 5, 16'hABAB));
    check("R4 lui", wbData, 32'hABAB0000);
    issue(iEnc(13, 5, 5, 16'hCDCD));
    check("R3 ori zero-ext R7 raw", wbData, 32'hABABCDCD);
    // R3: addi with negative immediate
    issue(iEnc(8, 0, 6, 16'hFFCE));
    check("R3 addi -50", wbData, 32'hFFFFFFCE);
    // R5: signed vs unsigned compare on differing signs (r6 negative, r7 = 1)
    issue(iEnc(8, 0, 7, 16'd1));
    issue(rEnc(6, 7, 8, 0, 42));
    check("R5 slt signed", wbData, 32'd1);
    issue(rEnc(6, 7, 9, 0, 43));
    check("R5 sltu unsigned", wbData, 32'd0);
    // R5/R3: sltiu with all-ones immediate sign-extends to 0xFFFFFFFF
    issue(iEnc(11, 7, 10, 16'hFFFF));
    check("R5 sltiu sext", wbData, 32'd1);
    issue(iEnc(10, 7, 11, 16'hFFFF));
    check("R5 slti signed", wbData, 32'd0);
    // R2: sub wraps
    issue(rEnc(0, 7, 12, 0, 34));
    check("R2 sub wrap", wbData, 32'hFFFFFFFF);
    // R6: write to r0 dropped, r0 still zero
    issue(iEnc(8, 0, 0, 16'd5));
    issue(rEnc(0, 0, 13, 0, 32));
    check("R6 r0 reads zero", wbData, 32'd0);
    // R8: nonzero shamt, unknown funct, unknown opcode
    issue(rEnc(7, 7, 14, 3, 32));
    issue(rEnc(7, 7, 14, 0, 36));
    issue(iEnc(35, 7, 14, 16'h1234));
    issue(rEnc(14, 0, 15, 0, 32));
    check("R8 no write r14", wbData, mdl[14]);
    idle();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int kind = int'($urandom % 14);
      int rs = int'($urandom % 32), rt = int'($urandom % 32), rd = int'($urandom % 32);
      logic [15:0] imm = 16'($urandom);
      int fnTab[4] = '{32, 34, 42, 43};
      int opTab[5] = '{8, 10, 11, 13, 15};
      if (kind < 4) issue(rEnc(rs, rt, rd, 0, fnTab[kind]));
      else if (kind < 9) issue(iEnc(opTab[kind-4], rs, rt, imm));
      else if (kind == 9) issue(rEnc(rs, rt, rd, 1 + int'($urandom % 31), fnTab[$urandom % 4]));
      else if (kind == 10) begin
        int op = int'($urandom % 64);
        if (op == 0 || op == 8 || op == 10 || op == 11 || op == 13 || op == 15) op = 63;
        issue(iEnc(op, rs, rt, imm));
      end
      else if (kind == 11) issue(rEnc(rs, rt, rd, 0, 33));
      else if (kind == 12) idle();
      else issue(rEnc(rs, 0, rd, 0, 32));
    end

    @(negedge clk);
    instrValid = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule